// File: doc/BRIEF.md
# Strobed Nibble Port Transfer Sequencer

This block runs one timed transfer on either of two 4-bit open-drain ports: a data port and a parameter port. Each port has its own active-low strobe. The frame logic starts a transfer with a one-clock request. The request carries an output nibble for each port, a port select and a flag that marks a master data call. The block then lowers the strobe of the selected port and applies the output nibble early in the strobe's low phase. It samples the port pins in a fixed window well after the strobe has gone back high. At the end it hands the captured nibble back with a one-clock valid pulse.

Timing is counted in ticks. A tick is `TICK_DIV` clocks, and is meant to be about one microsecond. The strobe stays low for ticks 0 to 5. New outputs take effect at tick 1. Inputs are captured on the clock that enters tick 11. The response comes out when tick 12 ends. A configuration code sets the direction of each data bit to output, input or output-until-strobe-release. It sets the parameter port as a whole to output or input. A soft reset aborts any transfer, releases every open-drain stage and emits one standalone strobe on both ports at once.

Top module: `strobe_port_seq`

## Requirements
- R1: After reset both strobes are released (`dataStbLow`=0, `parStbLow`=0), no pin is pulled low, and `rspValid` and `busy` are 0.
- R2: A request pulse on `reqValid` starts a transfer two clocks later. The selected port's strobe (`reqSelPar`=0 data, 1 parameter) is pulled low for exactly 6 ticks. The other strobe stays released throughout.
- R3: Data bit i has the direction (cfgCode + i) mod 3, sampled when the transfer starts: 0 = input (never pulled), 1 = output, 2 = output/input. A driving bit is pulled low when its output value is 0 and released when its output value is 1.
- R4: New port outputs take effect on the clock that enters tick 1. Data bits set as output keep their level until tick 1 of the next data-port transfer, and a parameter-port transfer leaves them unchanged.
- R5: Data bits set as output/input stop pulling on the same clock that the strobe is released (entry to tick 6).
- R6: Pins are sampled on the clock that enters tick 11. When tick 12 ends, `rspValid` is high for one clock and `rspNib` holds the sample. Data bits set as output read back 0.
- R7: The parameter port drives `reqParNib` on all four bits, and reads back 0. The one exception is cfgCode = 7 with `reqDataCall`=1. Then it pulls no bit, and the response is the `parPinIn` sample.
- R8: Parameter-port outputs keep their level until tick 1 of the next parameter-port transfer.
- R9: A request that arrives during a transfer is held. It starts on the clock after the current transfer ends. `busy` is 1 while a transfer runs or a request waits.
- R10: `softRst` aborts any transfer and drops a waiting request. From the next clock, no pin is pulled low and both strobes are low together for 6 ticks. No response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCode | input | 4 | I/O configuration code |
| reqValid | input | 1 | One-clock transfer request |
| reqSelPar | input | 1 | 0 selects the data port, 1 the parameter port |
| reqDataCall | input | 1 | The request is a master data call |
| reqDataNib | input | 4 | Output nibble for the data port |
| reqParNib | input | 4 | Output nibble for the parameter port |
| softRst | input | 1 | Soft reset pulse |
| dataPinIn | input | 4 | Data port pin levels |
| parPinIn | input | 4 | Parameter port pin levels |
| dataStbLow | output | 1 | Pull the data strobe pin low |
| parStbLow | output | 1 | Pull the parameter strobe pin low |
| dataPinLow | output | 4 | Pull-low enables of the data port pins |
| parPinLow | output | 4 | Pull-low enables of the parameter port pins |
| rspValid | output | 1 | Captured nibble is valid (one clock) |
| rspNib | output | 4 | Captured input nibble |
| busy | output | 1 | A transfer is running or waiting |

## Verification
The assertions assume two things about the inputs. `rspValid` pulses are spaced by a full transfer, and a soft reset always yields a strobe of exactly six ticks. Both hold only if `reqValid` and `softRst` are single-clock pulses and the requester does not send a new request while one is already waiting. The stimulus keeps to this: every request and soft reset lasts one clock, and at most one request waits at a time. The bench holds `cfgCode` steady from the request until the transfer starts. It moves the pin inputs only outside the capture clock, so that the sample is well defined.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_SOFT = 2'd2
  } seqState_e;

  localparam logic [1:0] DIR_IN    = 2'd0;
  localparam logic [1:0] DIR_OUT   = 2'd1;
  localparam logic [1:0] DIR_BIDIR = 2'd2;

  // Control strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic startCyc;
    logic softClr;
    logic loadOut;
    logic relBidir;
    logic capture;
    logic finish;
  } ctlStrobe_t;

  // Direction of one data bit: (code + bit index) mod 3
  function automatic logic [1:0] dirForBit(input logic [7:0] cfgExt, input int unsigned idx);
    logic [7:0] sum;
    sum = cfgExt + 8'(idx);
    return 2'(sum % 8'd3);
  endfunction

endpackage

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int TICK_DIV     = 200,
  parameter int STB_TICKS    = 6,
  parameter int DRIVE_TICK   = 1,
  parameter int CAPTURE_TICK = 11,
  parameter int CYCLE_TICKS  = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       softRst,
  output ctlStrobe_t ctl,
  output logic       strobeLow,
  output logic       inSoft,
  output logic       busy
);

  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int TCK_W = $clog2(CYCLE_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(TICK_DIV - 1);
  localparam logic [TCK_W-1:0] T_DRIVE   = TCK_W'(DRIVE_TICK - 1);
  localparam logic [TCK_W-1:0] T_RELEASE = TCK_W'(STB_TICKS - 1);
  localparam logic [TCK_W-1:0] T_CAPTURE = TCK_W'(CAPTURE_TICK - 1);
  localparam logic [TCK_W-1:0] T_LAST    = TCK_W'(CYCLE_TICKS - 1);
  localparam logic [TCK_W-1:0] T_STBEND  = TCK_W'(STB_TICKS);

  seqState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [TCK_W-1:0] tickCnt;
  logic             pendFlag;
  logic             tickEnd;

  assign tickEnd = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      tickCnt  <= '0;
      pendFlag <= 1'b0;
    end else if (softRst) begin
      state    <= ST_SOFT;
      divCnt   <= '0;
      tickCnt  <= '0;
      pendFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pendFlag) begin
            state    <= ST_XFER;
            divCnt   <= '0;
            tickCnt  <= '0;
            pendFlag <= reqValid;
          end else begin
            pendFlag <= reqValid;
          end
        end
        ST_XFER: begin
          pendFlag <= pendFlag | reqValid;
          if (tickEnd) begin
            divCnt <= '0;
            if (tickCnt == T_LAST) begin
              state   <= ST_IDLE;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_SOFT: begin
          pendFlag <= pendFlag | reqValid;
          if (tickEnd) begin
            divCnt <= '0;
            if (tickCnt == T_RELEASE) begin
              state   <= ST_IDLE;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic xferTickEnd;
  assign xferTickEnd = !softRst && (state == ST_XFER) && tickEnd;

  always_comb begin
    ctl          = '0;
    ctl.softClr  = softRst;
    ctl.startCyc = !softRst && (state == ST_IDLE) && pendFlag;
    ctl.loadOut  = xferTickEnd && (tickCnt == T_DRIVE);
    ctl.relBidir = xferTickEnd && (tickCnt == T_RELEASE);
    ctl.capture  = xferTickEnd && (tickCnt == T_CAPTURE);
    ctl.finish   = xferTickEnd && (tickCnt == T_LAST);
  end

  assign strobeLow = ((state == ST_XFER) || (state == ST_SOFT)) && (tickCnt < T_STBEND);
  assign inSoft    = (state == ST_SOFT);
  assign busy      = (state != ST_IDLE) || pendFlag;

endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import sps_pkg::*;
#(
  parameter int NIB_W        = 4,
  parameter int CFG_W        = 4,
  parameter int PAR_IN_CODE  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             reqValid,
  input  logic             reqSelPar,
  input  logic             reqDataCall,
  input  logic [NIB_W-1:0] reqDataNib,
  input  logic [NIB_W-1:0] reqParNib,
  input  logic [CFG_W-1:0] cfgCode,
  input  logic [NIB_W-1:0] dataPinIn,
  input  logic [NIB_W-1:0] parPinIn,
  output logic [NIB_W-1:0] dataPinLow,
  output logic [NIB_W-1:0] parPinLow,
  output logic             rspValid,
  output logic [NIB_W-1:0] rspNib,
  output logic             curSelPar
);

  localparam logic [CFG_W-1:0] PAR_IN_VAL = CFG_W'(PAR_IN_CODE);

  // waiting request payload
  logic             pSelPar, pDataCall;
  logic [NIB_W-1:0] pDataNib, pParNib;
  // current transfer
  logic             cParIn;
  logic [NIB_W-1:0] cDataNib, cParNib;
  logic [NIB_W-1:0][1:0] cMode;
  // port output state
  logic [NIB_W-1:0] dDrv, dVal, dBid;
  logic             pDrv;
  logic [NIB_W-1:0] pVal;
  logic [NIB_W-1:0] capNib;
  // per-bit decode of the latched directions
  logic [NIB_W-1:0] modeDrives, modeBidir, modeReads;

  genvar g;
  generate
    for (g = 0; g < NIB_W; g++) begin : g_bitDecode
      assign modeDrives[g] = (cMode[g] == DIR_OUT) || (cMode[g] == DIR_BIDIR);
      assign modeBidir[g]  = (cMode[g] == DIR_BIDIR);
      assign modeReads[g]  = (cMode[g] != DIR_OUT);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pSelPar   <= 1'b0;
      pDataCall <= 1'b0;
      pDataNib  <= '0;
      pParNib   <= '0;
      curSelPar <= 1'b0;
      cParIn    <= 1'b0;
      cDataNib  <= '0;
      cParNib   <= '0;
      cMode     <= '0;
      dDrv      <= '0;
      dVal      <= '0;
      dBid      <= '0;
      pDrv      <= 1'b0;
      pVal      <= '0;
      capNib    <= '0;
      rspValid  <= 1'b0;
      rspNib    <= '0;
    end else begin
      rspValid <= 1'b0;
      if (reqValid && !ctl.softClr) begin
        pSelPar   <= reqSelPar;
        pDataCall <= reqDataCall;
        pDataNib  <= reqDataNib;
        pParNib   <= reqParNib;
      end
      if (ctl.softClr) begin
        dDrv <= '0;
        dBid <= '0;
        pDrv <= 1'b0;
      end else begin
        if (ctl.startCyc) begin
          curSelPar <= pSelPar;
          cParIn    <= pSelPar && pDataCall && (cfgCode == PAR_IN_VAL);
          cDataNib  <= pDataNib;
          cParNib   <= pParNib;
          for (int i = 0; i < NIB_W; i++) begin
            cMode[i] <= dirForBit(8'(cfgCode), i);
          end
        end
        if (ctl.loadOut) begin
          if (curSelPar) begin
            pDrv <= !cParIn;
            pVal <= cParNib;
          end else begin
            dDrv <= modeDrives;
            dVal <= cDataNib;
            dBid <= modeBidir;
          end
        end
        if (ctl.relBidir && !curSelPar) begin
          dDrv <= dDrv & ~dBid;
        end
        if (ctl.capture) begin
          if (curSelPar) begin
            capNib <= cParIn ? parPinIn : '0;
          end else begin
            capNib <= dataPinIn & modeReads;
          end
        end
        if (ctl.finish) begin
          rspValid <= 1'b1;
          rspNib   <= capNib;
        end
      end
    end
  end

  assign dataPinLow = dDrv & ~dVal;
  assign parPinLow  = {NIB_W{pDrv}} & ~pVal;

endmodule

// File: rtl/strobe_port_seq.sv
module strobe_port_seq
  import sps_pkg::*;
#(
  parameter int NIB_W        = 4,
  parameter int CFG_W        = 4,
  parameter int PAR_IN_CODE  = 7,
  parameter int TICK_DIV     = 200,
  parameter int STB_TICKS    = 6,
  parameter int DRIVE_TICK   = 1,
  parameter int CAPTURE_TICK = 11,
  parameter int CYCLE_TICKS  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgCode,
  input  logic             reqValid,
  input  logic             reqSelPar,
  input  logic             reqDataCall,
  input  logic [NIB_W-1:0] reqDataNib,
  input  logic [NIB_W-1:0] reqParNib,
  input  logic             softRst,
  input  logic [NIB_W-1:0] dataPinIn,
  input  logic [NIB_W-1:0] parPinIn,
  output logic             dataStbLow,
  output logic             parStbLow,
  output logic [NIB_W-1:0] dataPinLow,
  output logic [NIB_W-1:0] parPinLow,
  output logic             rspValid,
  output logic [NIB_W-1:0] rspNib,
  output logic             busy
);

  ctlStrobe_t ctl;
  logic       strobeLow, inSoft, curSelPar;

  sps_ctrl #(
    .TICK_DIV    (TICK_DIV),
    .STB_TICKS   (STB_TICKS),
    .DRIVE_TICK  (DRIVE_TICK),
    .CAPTURE_TICK(CAPTURE_TICK),
    .CYCLE_TICKS (CYCLE_TICKS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .softRst  (softRst),
    .ctl      (ctl),
    .strobeLow(strobeLow),
    .inSoft   (inSoft),
    .busy     (busy)
  );

  sps_datapath #(
    .NIB_W      (NIB_W),
    .CFG_W      (CFG_W),
    .PAR_IN_CODE(PAR_IN_CODE)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqValid   (reqValid),
    .reqSelPar  (reqSelPar),
    .reqDataCall(reqDataCall),
    .reqDataNib (reqDataNib),
    .reqParNib  (reqParNib),
    .cfgCode    (cfgCode),
    .dataPinIn  (dataPinIn),
    .parPinIn   (parPinIn),
    .dataPinLow (dataPinLow),
    .parPinLow  (parPinLow),
    .rspValid   (rspValid),
    .rspNib     (rspNib),
    .curSelPar  (curSelPar)
  );

  assign dataStbLow = strobeLow && (inSoft || !curSelPar);
  assign parStbLow  = strobeLow && (inSoft || curSelPar);

endmodule

// File: rtl/strobe_port_seq_chk.sv
module strobe_port_seq_chk #(
  parameter int NIB_W     = 4,
  parameter int TICK_DIV  = 200,
  parameter int STB_TICKS = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             softRst,
  input logic             dataStbLow,
  input logic             parStbLow,
  input logic [NIB_W-1:0] dataPinLow,
  input logic [NIB_W-1:0] parPinLow,
  input logic             rspValid,
  input logic             busy
);

  localparam int STB_CLKS = STB_TICKS * TICK_DIV;

  int dLowCnt, pLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dLowCnt <= 0;
      pLowCnt <= 0;
    end else begin
      dLowCnt <= (dataStbLow && !softRst) ? dLowCnt + 1 : 0;
      pLowCnt <= (parStbLow && !softRst) ? pLowCnt + 1 : 0;
    end
  end

  // R2 / R10: every strobe low phase lasts the strobe window
  a_r2_data_stb_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataStbLow) |-> (dLowCnt == STB_CLKS));

  a_r2_par_stb_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parStbLow) |-> (pLowCnt == STB_CLKS));

  // R6: response valid is a single-clock pulse
  a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R10: soft reset releases every pin and lowers both strobes
  a_r10_soft_release: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (dataPinLow == '0 && parPinLow == '0 && dataStbLow && parStbLow));

  // R10: soft reset yields no response
  a_r10_soft_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !rspValid);

  // R9: a strobe only moves while the block reports busy
  a_r9_busy_stb: assert property (@(posedge clk) disable iff (!rstN)
    (dataStbLow || parStbLow) |-> busy);

endmodule

bind strobe_port_seq strobe_port_seq_chk #(
  .NIB_W    (NIB_W),
  .TICK_DIV (TICK_DIV),
  .STB_TICKS(STB_TICKS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .softRst   (softRst),
  .dataStbLow(dataStbLow),
  .parStbLow (parStbLow),
  .dataPinLow(dataPinLow),
  .parPinLow (parPinLow),
  .rspValid  (rspValid),
  .busy      (busy)
);

// File: tb/strobe_port_seq_tb_top.sv
`timescale 1ns/1ps
module strobe_port_seq_tb_top;

  localparam int TD = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgCode = '0;
  logic       reqValid = 1'b0, reqSelPar = 1'b0, reqDataCall = 1'b0;
  logic [3:0] reqDataNib = '0, reqParNib = '0;
  logic       softRst = 1'b0;
  logic [3:0] dataPinIn = '0, parPinIn = '0;
  logic       dataStbLow, parStbLow, rspValid, busy;
  logic [3:0] dataPinLow, parPinLow, rspNib;

  int  checks = 0, errors = 0;
  bit  finished = 0;
  logic [3:0] expQ[$];
  logic [3:0] expDLow = '0, expPLow = '0;

  always #2.5 clk = ~clk;

  strobe_port_seq #(.TICK_DIV(TD)) dut_i (
    .clk(clk), .rstN(rstN), .cfgCode(cfgCode), .reqValid(reqValid),
    .reqSelPar(reqSelPar), .reqDataCall(reqDataCall), .reqDataNib(reqDataNib),
    .reqParNib(reqParNib), .softRst(softRst), .dataPinIn(dataPinIn),
    .parPinIn(parPinIn), .dataStbLow(dataStbLow), .parStbLow(parStbLow),
    .dataPinLow(dataPinLow), .parPinLow(parPinLow), .rspValid(rspValid),
    .rspNib(rspNib), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R3 direction rule
  function automatic int modeOf(input logic [3:0] cfg, input int i);
    return (int'(cfg) + i) % 3;
  endfunction

  // monitor: pops expected responses
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected response actual %0h expected none", rspNib);
      end else begin
        logic [3:0] e;
        e = expQ.pop_front();
        if (rspNib !== e) begin
          errors++;
          $display("FAIL R6: response actual %0h expected %0h", rspNib, e);
        end
      end
    end
  end

  task automatic issueReq(input logic sp, input logic dc, input logic [3:0] dn, input logic [3:0] pn);
    reqSelPar = sp; reqDataCall = dc; reqDataNib = dn; reqParNib = pn;
    reqValid = 1'b1;
    waitEdges(1);
    reqValid = 1'b0;
  endtask

  // Called one ns after the clock that enters tick 0 of a transfer
  task automatic runChecks(input logic sp, input logic dc, input logic [3:0] dn,
                           input logic [3:0] pn, input logic [3:0] cfg,
                           input logic [3:0] dPin, input logic [3:0] pPin);
    logic [3:0] bid, rsp;
    logic parIn;
    bid = '0; rsp = '0;
    parIn = sp && dc && (cfg == 4'd7);
    dataPinIn = ~dPin; parPinIn = ~pPin;
    chk("R2 selected strobe low", sp ? parStbLow : dataStbLow, 1);
    chk("R2 other strobe released", sp ? dataStbLow : parStbLow, 0);
    chk("R4 data pins before tick1", dataPinLow, expDLow);
    chk("R8 par pins before tick1", parPinLow, expPLow);
    waitEdges(TD);
    if (sp) begin
      expPLow = parIn ? 4'h0 : ~pn;
      rsp = parIn ? pPin : 4'h0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        int m;
        m = modeOf(cfg, i);
        expDLow[i] = (m != 0) ? ~dn[i] : 1'b0;
        bid[i] = (m == 2);
        rsp[i] = (m != 1) ? dPin[i] : 1'b0;
      end
    end
    chk("R3 data pins at tick1", dataPinLow, expDLow);
    chk("R7 par pins at tick1", parPinLow, expPLow);
    chk("R9 busy during transfer", busy, 1);
    waitEdges(5 * TD - 1);
    chk("R2 strobe low at end of tick5", sp ? parStbLow : dataStbLow, 1);
    waitEdges(1);
    expDLow = expDLow & ~bid;
    chk("R2 strobe released at tick6", sp ? parStbLow : dataStbLow, 0);
    chk("R5 bidir released at tick6", dataPinLow, expDLow);
    waitEdges(4 * TD);
    dataPinIn = dPin; parPinIn = pPin;
    waitEdges(2 * TD);
    dataPinIn = ~dPin; parPinIn = ~pPin;
    expQ.push_back(rsp);
    waitEdges(TD);
    chk("R6 response valid at end", rspValid, 1);
    chk("R4 data pins hold after transfer", dataPinLow, expDLow);
    chk("R8 par pins hold after transfer", parPinLow, expPLow);
  endtask

  task automatic oneXfer(input logic sp, input logic dc, input logic [3:0] dn,
                         input logic [3:0] pn, input logic [3:0] cfg,
                         input logic [3:0] dPin, input logic [3:0] pPin);
    cfgCode = cfg;
    issueReq(sp, dc, dn, pn);
    chk("R2 strobe not yet low one clock after request", dataStbLow | parStbLow, 0);
    waitEdges(1);
    runChecks(sp, dc, dn, pn, cfg, dPin, pPin);
    waitEdges(2);
  endtask

  task automatic finish_run();
    chk("R6 all responses seen", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitEdges(3);
    #0.5;
    chk("R1 data strobe in reset", dataStbLow, 0);
    rstN = 1'b1;
    waitEdges(2);
    chk("R1 data strobe released", dataStbLow, 0);
    chk("R1 par strobe released", parStbLow, 0);
    chk("R1 no data pin pulled", dataPinLow, 0);
    chk("R1 no par pin pulled", parPinLow, 0);
    chk("R1 no response", rspValid, 0);
    chk("R1 not busy", busy, 0);

    // data port, three direction patterns
    oneXfer(1'b0, 1'b0, 4'b0000, 4'h0, 4'd1, 4'b1111, 4'h0);
    oneXfer(1'b0, 1'b0, 4'b1010, 4'h0, 4'd0, 4'b0101, 4'h0);
    oneXfer(1'b0, 1'b1, 4'b0101, 4'hF, 4'd2, 4'b1001, 4'h0);
    // parameter port: output, code 7 without data call, input
    oneXfer(1'b1, 1'b1, 4'h0, 4'b0011, 4'd3, 4'h0, 4'hA);
    oneXfer(1'b1, 1'b0, 4'h0, 4'b0110, 4'd7, 4'h0, 4'hA);
    oneXfer(1'b1, 1'b1, 4'h0, 4'b0000, 4'd7, 4'h0, 4'b1101);
    oneXfer(1'b1, 1'b0, 4'h0, 4'b1001, 4'd5, 4'h0, 4'h3);

    // R9: request while busy is held
    cfgCode = 4'd4;
    issueReq(1'b0, 1'b0, 4'b0011, 4'h0);
    waitEdges(1);
    fork
      runChecks(1'b0, 1'b0, 4'b0011, 4'h0, 4'd4, 4'b0110, 4'h0);
      begin
        waitEdges(3 * TD);
        issueReq(1'b1, 1'b0, 4'h0, 4'b1110);
      end
    join
    chk("R9 held request waits, busy", busy, 1);
    chk("R9 held request not started", dataStbLow | parStbLow, 0);
    waitEdges(1);
    runChecks(1'b1, 1'b0, 4'h0, 4'b1110, 4'd4, 4'h0, 4'h5);
    waitEdges(2);

    // R10: soft reset after strobe, with a waiting request
    cfgCode = 4'd1;
    issueReq(1'b0, 1'b0, 4'b0000, 4'h0);
    waitEdges(1);
    waitEdges(TD);
    chk("R10 pins driven before soft reset", dataPinLow, 4'b1011);
    waitEdges(2 * TD);
    issueReq(1'b1, 1'b0, 4'h0, 4'h0);
    waitEdges(5 * TD);
    softRst = 1'b1;
    waitEdges(1);
    softRst = 1'b0;
    expDLow = '0; expPLow = '0;
    chk("R10 data pins released", dataPinLow, 0);
    chk("R10 par pins released", parPinLow, 0);
    chk("R10 data strobe low", dataStbLow, 1);
    chk("R10 par strobe low", parStbLow, 1);
    waitEdges(6 * TD - 1);
    chk("R10 both strobes still low", dataStbLow & parStbLow, 1);
    waitEdges(1);
    chk("R10 strobes released after window", dataStbLow | parStbLow, 0);
    waitEdges(3 * TD);
    chk("R10 waiting request dropped", busy, 0);
    chk("R10 no strobe after soft reset", dataStbLow | parStbLow, 0);

    // normal transfer after soft reset
    oneXfer(1'b0, 1'b0, 4'b1100, 4'h0, 4'd2, 4'b0011, 4'h0);
    finish_run();
  end

endmodule